// File: doc/BRIEF.md
# Masked Two-Port Coincidence Trigger

This block watches two 32-bit input ports and raises a one-cycle trigger whenever a masked combination of them becomes true. Each port has its own 32-bit enable mask. In AND mode a bit position counts only when both ports are high there and both masks enable it. In OR mode any enabled high bit on either port counts. The trigger is the rising edge of the combined condition, registered, and is meant to start a downstream gate generator.

A 16-bit register bus with single-cycle write and read strobes gives software access. It can read the state of all three ports as low and high 16-bit halves, write and read back the masks and the port C control word, and write a mode word. The mode word picks the combining logic and says whether port C is an output driven from the control word or an input that is only observed.

Top module: `coinc_trig_unit`

## Requirements
- R1: After reset, all masks, the port C control word and the mode word are 0, so trig_out is 0, port_c_oe is 0, port_c_out is 0 and rdata is 0.
- R2: With mode bit 0 cleared (AND mode), the combined condition is true when some bit i has port_a_in[i], port_b_in[i], mask A bit i and mask B bit i all equal to 1.
- R3: With mode bit 0 set (OR mode), the combined condition is true when some bit of port_a_in is 1 with its mask A bit set, or some bit of port_b_in is 1 with its mask B bit set.
- R4: An input bit whose mask bit is 0 never affects the combined condition. Mask bit value 1 enables a bit.
- R5: trig_out is high for exactly one cycle per rising edge of the combined condition. An input change applied before clock edge k shows on trig_out after edge k+1. A condition that stays true gives no further pulse.
- R6: Port status reads return the captured port pins, low half at the lower address: A at 0x0000/0x0002, B at 0x0004/0x0006, C at 0x0008/0x000A.
- R7: Read data appears on rdata in the cycle after the read strobe and is 0x0000 in every other cycle. Reads of any address not listed in R6, R8 or R10 return 0x0000.
- R8: The mode word is written at 0x001E and reads back as 0x0000. Bit 0 selects OR mode, bit 1 makes port C an output.
- R9: With mode bit 1 set, port_c_oe is 1 and port_c_out equals the control word (high half in bits 31..16). With it cleared, port_c_oe is 0 and port_c_out is 0.
- R10: Mask A halves sit at 0x0010/0x0012, mask B halves at 0x0014/0x0016 and the port C control halves at 0x0018/0x001A, each written and read back as 16 bits, low half first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| addr | input | 16 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_stb |
| port_a_in | input | 32 | Port A inputs |
| port_b_in | input | 32 | Port B inputs |
| port_c_in | input | 32 | Port C pins as observed |
| port_c_out | output | 32 | Port C drive value |
| port_c_oe | output | 1 | Port C output enable |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
The combining logic is tried with matching single bits at the low, middle and top positions, with adjacent but different bits that must not coincide in AND mode, and with all-ones inputs under all-zero masks. These cases separate AND from OR and show whether a mask wrongly enables or disables a bit. Split masks that cover only one half of the word show whether the halves are wired to the right addresses. A held condition followed by a release and a new rise shows that the trigger follows edges and not levels.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] ST_BASE   = 16'h0000;
  localparam logic [ADDR_W-1:0] MSKA_BASE = 16'h0010;
  localparam logic [ADDR_W-1:0] MSKB_BASE = 16'h0014;
  localparam logic [ADDR_W-1:0] CTL_BASE  = 16'h0018;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 16'h001E;
  localparam int MODE_W        = 2;
  localparam int MODE_OR_BIT   = 0;
  localparam int MODE_COUT_BIT = 1;
endpackage

// File: rtl/ctu_coinc.sv
module ctu_coinc #(
  parameter int PORT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] a_in,
  input  logic [PORT_W-1:0] b_in,
  input  logic [PORT_W-1:0] mask_a,
  input  logic [PORT_W-1:0] mask_b,
  input  logic              sel_or,
  output logic [PORT_W-1:0] a_cap,
  output logic [PORT_W-1:0] b_cap,
  output logic              trig
);
  logic [PORT_W-1:0] a_q, b_q;
  logic [PORT_W-1:0] a_en, b_en;
  logic              coin_now, coin_q, trig_d;

  // masked operands and the combining function
  always_comb begin
    a_en = a_q & mask_a;
    b_en = b_q & mask_b;
    if (sel_or) coin_now = (|a_en) | (|b_en);
    else        coin_now = |(a_en & b_en);
    trig_d = coin_now & ~coin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      coin_q <= 1'b0;
      trig   <= 1'b0;
    end else begin
      a_q    <= a_in;
      b_q    <= b_in;
      coin_q <= coin_now;
      trig   <= trig_d;
    end
  end

  assign a_cap = a_q;
  assign b_cap = b_q;

  // R5: a pulse never lasts two cycles
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  // R4: with every bit disabled no pulse can follow
  a_r4_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_a == '0 && mask_b == '0) |=> !trig);
endmodule

// File: rtl/ctu_regfile.sv
module ctu_regfile
  import ctu_pkg::*;
#(
  parameter int PORT_W = 32,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [PORT_W-1:0] st_a,
  input  logic [PORT_W-1:0] st_b,
  input  logic [PORT_W-1:0] st_c,
  output logic [PORT_W-1:0] mask_a,
  output logic [PORT_W-1:0] mask_b,
  output logic [PORT_W-1:0] ctl_c,
  output logic              mode_or,
  output logic              mode_cout
);
  localparam int HALVES = PORT_W / REG_W;

  logic [HALVES-1:0][REG_W-1:0] mska_q, mska_d, mskb_q, mskb_d, ctl_q, ctl_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [REG_W-1:0]  rd_d, rd_q;

  // write decode
  always_comb begin
    mska_d = mska_q;
    mskb_d = mskb_q;
    ctl_d  = ctl_q;
    mode_d = mode_q;
    if (wr_stb) begin
      for (int h = 0; h < HALVES; h++) begin
        if (addr == MSKA_BASE + ADDR_W'(2*h)) mska_d[h] = wdata;
        if (addr == MSKB_BASE + ADDR_W'(2*h)) mskb_d[h] = wdata;
        if (addr == CTL_BASE  + ADDR_W'(2*h)) ctl_d[h]  = wdata;
      end
      if (addr == MODE_ADDR) mode_d = wdata[MODE_W-1:0];
    end
  end

  // read decode: unmapped and write-only addresses give zero
  always_comb begin
    rd_d = '0;
    if (rd_stb) begin
      for (int h = 0; h < HALVES; h++) begin
        if (addr == ST_BASE + ADDR_W'(2*h))            rd_d = st_a[h*REG_W +: REG_W];
        if (addr == ST_BASE + ADDR_W'(2*(HALVES+h)))   rd_d = st_b[h*REG_W +: REG_W];
        if (addr == ST_BASE + ADDR_W'(2*(2*HALVES+h))) rd_d = st_c[h*REG_W +: REG_W];
        if (addr == MSKA_BASE + ADDR_W'(2*h))          rd_d = mska_q[h];
        if (addr == MSKB_BASE + ADDR_W'(2*h))          rd_d = mskb_q[h];
        if (addr == CTL_BASE  + ADDR_W'(2*h))          rd_d = ctl_q[h];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mska_q <= '0;
      mskb_q <= '0;
      ctl_q  <= '0;
      mode_q <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_stb) begin
        mska_q <= mska_d;
        mskb_q <= mskb_d;
        ctl_q  <= ctl_d;
        mode_q <= mode_d;
      end
      rd_q <= rd_d;
    end
  end

  assign mask_a    = mska_q;
  assign mask_b    = mskb_q;
  assign ctl_c     = ctl_q;
  assign mode_or   = mode_q[MODE_OR_BIT];
  assign mode_cout = mode_q[MODE_COUT_BIT];
  assign rdata     = rd_q;

  // R7: read data is zero unless a strobe came the cycle before
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> rdata == '0);
  // R8: the mode word changes only through its own address
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && addr == MODE_ADDR) |=> $stable(mode_q));
endmodule

// File: rtl/coinc_trig_unit.sv
module coinc_trig_unit
  import ctu_pkg::*;
#(
  parameter int PORT_W = 32,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [15:0]       addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [PORT_W-1:0] port_a_in,
  input  logic [PORT_W-1:0] port_b_in,
  input  logic [PORT_W-1:0] port_c_in,
  output logic [PORT_W-1:0] port_c_out,
  output logic              port_c_oe,
  output logic              trig_out
);
  logic [PORT_W-1:0] mask_a, mask_b, ctl_c, a_cap, b_cap, c_q;
  logic              mode_or, mode_cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= '0;
    else        c_q <= port_c_in;
  end

  ctu_coinc #(.PORT_W(PORT_W)) i_coinc (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_in   (port_a_in),
    .b_in   (port_b_in),
    .mask_a (mask_a),
    .mask_b (mask_b),
    .sel_or (mode_or),
    .a_cap  (a_cap),
    .b_cap  (b_cap),
    .trig   (trig_out)
  );

  ctu_regfile #(.PORT_W(PORT_W), .REG_W(REG_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .st_a      (a_cap),
    .st_b      (b_cap),
    .st_c      (c_q),
    .mask_a    (mask_a),
    .mask_b    (mask_b),
    .ctl_c     (ctl_c),
    .mode_or   (mode_or),
    .mode_cout (mode_cout)
  );

  assign port_c_oe  = mode_cout;
  assign port_c_out = mode_cout ? ctl_c : '0;

  // R9: the port C driver turns on only after a register write
  a_r9_oe_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_c_oe) |-> $past(wr_stb));
endmodule

// File: tb/test_coinc_trig_unit.sv
module test_coinc_trig_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic [31:0] pa = '0, pb = '0, pc = '0;
  logic [31:0] pc_out;
  logic        pc_oe, trig;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  coinc_trig_unit i_coinc_trig_unit (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .port_a_in(pa), .port_b_in(pb), .port_c_in(pc),
    .port_c_out(pc_out), .port_c_oe(pc_oe), .trig_out(trig)
  );

  typedef struct packed {
    logic        use_or;
    logic [31:0] ma, mb, a, b;
    logic [1:0]  pulses;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000020, 32'h00000020, 2'd1},
    '{1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000020, 32'h00000040, 2'd0},
    '{1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h80000000, 2'd1},
    '{1'b0, 32'hFFFF0000, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 2'd0},
    '{1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00100000, 2'd1},
    '{1'b1, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'd0},
    '{1'b1, 32'h00000001, 32'h00000000, 32'h00000001, 32'h00000000, 2'd1},
    '{1'b0, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00010000, 32'h00010000, 2'd0},
    '{1'b0, 32'h80000001, 32'h80000001, 32'h80000000, 32'h80000001, 2'd1},
    '{1'b1, 32'h0000FF00, 32'h00000000, 32'h000000FF, 32'hFFFFFFFF, 2'd0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wr_stb = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); rd_stb = 1'b1; addr = a;
    @(negedge clk); rd_stb = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trig) c++;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int c;
    idle(3);
    // R1 reset state
    check(trig == 1'b0 && pc_oe == 1'b0, "R1 trig/oe", {trig, pc_oe}, 0);
    check(pc_out == '0, "R1 port_c_out", pc_out, 0);
    check(rdata == '0, "R1 rdata", rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(16'h0010, d); check(d == 16'h0000, "R1 mask A reset", d, 0);
    rd(16'h001A, d); check(d == 16'h0000, "R1 control reset", d, 0);

    // vector table: R2 R3 R4 R5
    foreach (VEC[i]) begin
      pa = '0; pb = '0;
      idle(4);
      wr(16'h0010, VEC[i].ma[15:0]);  wr(16'h0012, VEC[i].ma[31:16]);
      wr(16'h0014, VEC[i].mb[15:0]);  wr(16'h0016, VEC[i].mb[31:16]);
      wr(16'h001E, {15'd0, VEC[i].use_or});
      idle(3);
      pa = VEC[i].a; pb = VEC[i].b;
      count_pulses(8, c);
      check(c == int'(VEC[i].pulses),
            VEC[i].use_or ? $sformatf("R3/R4 vector %0d", i) : $sformatf("R2/R4 vector %0d", i),
            c, VEC[i].pulses);
    end

    // R5 exact latency, edge behaviour with a held and re-risen condition
    pa = '0; pb = '0;
    wr(16'h001E, 16'h0000);
    idle(4);
    @(negedge clk); pa = 32'h00000100; pb = 32'h00000100;  // masks are all ones from vector 9? set them
    pa = '0; pb = '0;
    wr(16'h0010, 16'hFFFF); wr(16'h0012, 16'hFFFF);
    wr(16'h0014, 16'hFFFF); wr(16'h0016, 16'hFFFF);
    idle(4);
    pa = 32'h00000100; pb = 32'h00000100;
    @(negedge clk); check(trig == 1'b0, "R5 no pulse after first edge", trig, 0);
    @(negedge clk); check(trig == 1'b1, "R5 pulse after second edge", trig, 1);
    @(negedge clk); check(trig == 1'b0, "R5 pulse is one cycle", trig, 0);
    count_pulses(6, c); check(c == 0, "R5 held condition", c, 0);
    pa = '0; idle(3);
    pa = 32'h00000100;
    count_pulses(6, c); check(c == 1, "R5 re-rise", c, 1);

    // R6 status reads
    pa = 32'h1234ABCD; pb = 32'h55AA0F0F; pc = 32'hDEAD0001;
    idle(3);
    rd(16'h0000, d); check(d == 16'hABCD, "R6 A low", d, 16'hABCD);
    rd(16'h0002, d); check(d == 16'h1234, "R6 A high", d, 16'h1234);
    rd(16'h0004, d); check(d == 16'h0F0F, "R6 B low", d, 16'h0F0F);
    rd(16'h0006, d); check(d == 16'h55AA, "R6 B high", d, 16'h55AA);
    rd(16'h0008, d); check(d == 16'h0001, "R6 C low", d, 16'h0001);
    rd(16'h000A, d); check(d == 16'hDEAD, "R6 C high", d, 16'hDEAD);

    // R7 timing and unmapped addresses
    @(negedge clk); check(rdata == 16'h0000, "R7 zero after read cycle", rdata, 0);
    rd(16'h000C, d); check(d == 16'h0000, "R7 unmapped 0x000C", d, 0);
    rd(16'h0003, d); check(d == 16'h0000, "R7 odd address", d, 0);
    rd(16'h0100, d); check(d == 16'h0000, "R7 unmapped 0x0100", d, 0);

    // R10 mask and control read-back
    wr(16'h0014, 16'hC3C3); wr(16'h0016, 16'h3C3C);
    rd(16'h0014, d); check(d == 16'hC3C3, "R10 mask B low", d, 16'hC3C3);
    rd(16'h0016, d); check(d == 16'h3C3C, "R10 mask B high", d, 16'h3C3C);
    wr(16'h0018, 16'hBEEF); wr(16'h001A, 16'hCAFE);
    rd(16'h0018, d); check(d == 16'hBEEF, "R10 control low", d, 16'hBEEF);
    rd(16'h001A, d); check(d == 16'hCAFE, "R10 control high", d, 16'hCAFE);

    // R9 port C direction; R8 mode write-only
    @(negedge clk); check(pc_oe == 1'b0 && pc_out == '0, "R9 input mode", pc_out, 0);
    wr(16'h001E, 16'h0002);
    check(pc_oe == 1'b1, "R9 oe set", pc_oe, 1);
    check(pc_out == 32'hCAFEBEEF, "R9 output value", pc_out, 32'hCAFEBEEF);
    rd(16'h001E, d); check(d == 16'h0000, "R8 mode reads zero", d, 0);
    wr(16'h001E, 16'h0000);
    check(pc_oe == 1'b0 && pc_out == '0, "R9 back to input", pc_out, 0);

    // R8 mode bit 0 picks OR: only port A bit set, mask A enabled
    pa = '0; pb = '0;
    wr(16'h0010, 16'h0001); wr(16'h0014, 16'h0000); wr(16'h0016, 16'h0000);
    idle(3);
    pa = 32'h00000001;
    count_pulses(6, c); check(c == 0, "R8 AND selected", c, 0);
    pa = '0; idle(3);
    wr(16'h001E, 16'h0001); idle(3);
    pa = 32'h00000001;
    count_pulses(6, c); check(c == 1, "R8 OR selected", c, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule